// File: doc/BRIEF.md
# Speculative Load Address Hazard Gate

This block decides, once per cycle, whether a speculative load may start its memory access. The core presents one load request (its reorder-buffer slot and its effective address) together with a snapshot of every reorder-buffer slot that holds a store: whether the slot is an active store, whether its address has been computed, and that address. The block finds the stores that are older than the load, using slot distances from the head pointer so that index wraparound is handled. It then holds the load back while any of those older stores writes the same address, or has not yet produced an address.

Stores write memory only at commit, from the head of the buffer. Write-after-read and write-after-write ordering through memory therefore needs no check here, and younger stores never affect the decision. The verdict is registered. It is recomputed from the current snapshot every cycle, so a stall ends one cycle after the offending store leaves the snapshot or its address stops matching.

Top module: `spec_load_gate`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `ld_go`, `ld_stall`, `ld_stall_hit` and `ld_stall_unk` are all 0.
- R2: If `ld_req` is 1 and some older slot has `st_valid`=1, `st_known`=1 and an address equal to `ld_addr` in all bits, then in the next cycle `ld_stall`=1, `ld_stall_hit`=1 and `ld_go`=0.
- R3: If `ld_req` is 1 and some older slot has `st_valid`=1 and `st_known`=0, then in the next cycle `ld_stall`=1, `ld_stall_unk`=1 and `ld_go`=0, whatever that slot's address field holds.
- R4: Slots that are younger than the load, and the load's own slot, have no effect on the outputs, whatever their address or known bit.
- R5: Slots with `st_valid`=0 have no effect on the outputs.
- R6: Slot j is older than the load exactly when (j - head) mod DEPTH < (ld_idx - head) mod DEPTH. This holds across index wraparound, and a load at the head slot has no older stores.
- R7: If `ld_req` is 1 and no older slot causes R2 or R3, then in the next cycle `ld_go`=1 and all stall outputs are 0.
- R8: If `ld_req` is 0, then in the next cycle all four outputs are 0.
- R9: The verdict depends only on the inputs sampled at the previous edge. A load that was stalled gets `ld_go`=1 in the cycle after the blocking store's slot shows `st_valid`=0.
- R10: `ld_go` and `ld_stall` are never 1 together. `ld_stall_hit` and `ld_stall_unk` can both be 1, and either one implies `ld_stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_req | input | 1 | A load asks to access memory this cycle |
| ld_idx | input | IW | Reorder-buffer slot of the load |
| ld_addr | input | AW | Effective address of the load |
| head | input | IW | Slot of the oldest uncommitted instruction |
| st_valid | input | DEPTH | Per slot: an active uncommitted store |
| st_known | input | DEPTH | Per slot: the store's address is computed |
| st_addr | input | DEPTH*AW | Per slot store address, slot j at bits j*AW +: AW |
| ld_go | output | 1 | Load may access memory |
| ld_stall | output | 1 | Load is held back |
| ld_stall_hit | output | 1 | An older store matches the address |
| ld_stall_unk | output | 1 | An older store's address is not yet known |

## Verification
The hardest situation to reach is a head pointer near the top of the index range with the load slot wrapped below it. In that case a matching store at a higher index is older and a matching store at a lower index is younger. Random stimulus rarely puts matching addresses on exactly the slots that expose a wrong age comparison. Directed cases therefore place a head of 6 and a load at slot 1, with equal addresses on both sides of the wrap. The random phase draws addresses from a four-value pool so that matches are frequent, and it picks head and load slots uniformly.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef struct packed {
    logic go;
    logic stall;
    logic hit;
    logic unk;
  } lsc_verdict_t;

  localparam lsc_verdict_t LSC_IDLE = '{go: 1'b0, stall: 1'b0, hit: 1'b0, unk: 1'b0};
endpackage

// File: rtl/lsc_older_mask.sv
module lsc_older_mask #(
  parameter int DEPTH = 8,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic [IW-1:0]    head,
  input  logic [IW-1:0]    ld_idx,
  output logic [DEPTH-1:0] older
);
  logic [IW-1:0] ld_dist;
  assign ld_dist = ld_idx - head;

  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    logic [IW-1:0] slot_dist;
    assign slot_dist = IW'(j) - head;
    assign older[j]  = (slot_dist < ld_dist);
  end
endmodule

// File: rtl/lsc_addr_match.sv
module lsc_addr_match #(
  parameter int DEPTH = 8,
  parameter int AW    = 32
) (
  input  logic [DEPTH-1:0]    st_valid,
  input  logic [DEPTH-1:0]    st_known,
  input  logic [DEPTH*AW-1:0] st_addr,
  input  logic [AW-1:0]       ld_addr,
  output logic [DEPTH-1:0]    hit_vec,
  output logic [DEPTH-1:0]    unk_vec
);
  for (genvar j = 0; j < DEPTH; j++) begin : g_cmp
    logic eq;
    assign eq         = (st_addr[j*AW +: AW] == ld_addr);
    assign hit_vec[j] = st_valid[j] & st_known[j] & eq;
    assign unk_vec[j] = st_valid[j] & ~st_known[j];
  end
endmodule

// File: rtl/spec_load_gate.sv
module spec_load_gate
  import lsc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_req,
  input  logic [IW-1:0]       ld_idx,
  input  logic [AW-1:0]       ld_addr,
  input  logic [IW-1:0]       head,
  input  logic [DEPTH-1:0]    st_valid,
  input  logic [DEPTH-1:0]    st_known,
  input  logic [DEPTH*AW-1:0] st_addr,
  output logic                ld_go,
  output logic                ld_stall,
  output logic                ld_stall_hit,
  output logic                ld_stall_unk
);
  logic [DEPTH-1:0] older;
  logic [DEPTH-1:0] hit_vec;
  logic [DEPTH-1:0] unk_vec;
  lsc_verdict_t     verdict_d;
  lsc_verdict_t     verdict_q;
  logic             verdict_en;

  lsc_older_mask #(.DEPTH(DEPTH), .IW(IW)) u_age (
    .head   (head),
    .ld_idx (ld_idx),
    .older  (older)
  );

  lsc_addr_match #(.DEPTH(DEPTH), .AW(AW)) u_cmp (
    .st_valid (st_valid),
    .st_known (st_known),
    .st_addr  (st_addr),
    .ld_addr  (ld_addr),
    .hit_vec  (hit_vec),
    .unk_vec  (unk_vec)
  );

  assign verdict_en = 1'b1;

  always_comb begin
    verdict_d = LSC_IDLE;
    if (ld_req) begin
      verdict_d.hit   = |(hit_vec & older);
      verdict_d.unk   = |(unk_vec & older);
      verdict_d.stall = verdict_d.hit | verdict_d.unk;
      verdict_d.go    = ~verdict_d.stall;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verdict_q <= LSC_IDLE;
    end else if (verdict_en) begin
      verdict_q <= verdict_d;
    end
  end

  assign ld_go        = verdict_q.go;
  assign ld_stall     = verdict_q.stall;
  assign ld_stall_hit = verdict_q.hit;
  assign ld_stall_unk = verdict_q.unk;

  // R10: grant and stall exclusive; a reason flag implies stall
  assert_go_stall_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_go && ld_stall) && ((ld_stall_hit || ld_stall_unk) == ld_stall));

  // R8: no request, no verdict next cycle
  assert_idle_no_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_req |=> (!ld_go && !ld_stall));

  // R6: load at head slot has no older store, so it is granted
  assert_head_load_go_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && ld_idx == head) |=> ld_go);

  // R3: unknown-address stall needs some active store without an address
  assert_unk_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(st_valid & ~st_known)) |=> !ld_stall_unk);

  // R5: with no active stores at all the load is never stalled
  assert_empty_go_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && st_valid == '0) |=> (ld_go && !ld_stall));
endmodule

// File: tb/spec_load_gate_bench.sv
`timescale 1ns/1ps
module spec_load_gate_bench;
  localparam int DEPTH = 8;
  localparam int AW    = 32;
  localparam int IW    = 3;

  logic                clk;
  logic                rst_n;
  logic                ld_req;
  logic [IW-1:0]       ld_idx;
  logic [AW-1:0]       ld_addr;
  logic [IW-1:0]       head;
  logic [DEPTH-1:0]    st_valid;
  logic [DEPTH-1:0]    st_known;
  logic [DEPTH*AW-1:0] st_addr;
  logic                ld_go, ld_stall, ld_stall_hit, ld_stall_unk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  spec_load_gate #(.DEPTH(DEPTH), .AW(AW)) u_spec_load_gate (
    .clk(clk), .rst_n(rst_n), .ld_req(ld_req), .ld_idx(ld_idx), .ld_addr(ld_addr),
    .head(head), .st_valid(st_valid), .st_known(st_known), .st_addr(st_addr),
    .ld_go(ld_go), .ld_stall(ld_stall), .ld_stall_hit(ld_stall_hit),
    .ld_stall_unk(ld_stall_unk)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // expected {go, stall, hit, unk}
  function automatic logic [3:0] model();
    logic hit = 1'b0;
    logic unk = 1'b0;
    int ld_d = (int'(ld_idx) - int'(head) + DEPTH) % DEPTH;
    if (!ld_req) return 4'b0000;
    for (int j = 0; j < DEPTH; j++) begin
      int d = (j - int'(head) + DEPTH) % DEPTH;
      if (d < ld_d && st_valid[j]) begin
        if (!st_known[j]) unk = 1'b1;
        else if (st_addr[j*AW +: AW] == ld_addr) hit = 1'b1;
      end
    end
    return {~(hit | unk), hit | unk, hit, unk};
  endfunction

  task automatic check(input logic [3:0] exp, input string tag);
    logic [3:0] act = {ld_go, ld_stall, ld_stall_hit, ld_stall_unk};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got go/stall/hit/unk=%b expected %b", tag, act, exp);
    end
  endtask

  // apply current inputs, let one edge pass, check at the next falling edge
  task automatic step(input string tag);
    logic [3:0] exp = model();
    @(posedge clk);
    @(negedge clk);
    check(exp, tag);
  endtask

  task automatic clear_slots();
    st_valid = '0; st_known = '0; st_addr = '0;
  endtask

  task automatic put(input int j, input logic v, input logic k, input logic [AW-1:0] a);
    st_valid[j] = v; st_known[j] = k; st_addr[j*AW +: AW] = a;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; ld_req = 1'b1; ld_idx = 3'd5; ld_addr = 32'h40; head = 3'd0;
    clear_slots(); put(1, 1, 1, 32'h40);
    repeat (3) @(negedge clk);
    check(4'b0000, "R1 in reset");
    ld_req = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check(4'b0000, "R1 after release");

    // R8: request low with a matching older store
    step("R8 no request");

    // R2: older known match
    ld_req = 1'b1;
    step("R2 older match");
    check(4'b0110, "R2 direct value");

    // R5: invalid slots ignored
    clear_slots(); put(1, 0, 1, 32'h40); put(2, 0, 0, 32'h0);
    step("R5 invalid slots");
    check(4'b1000, "R5 direct value");

    // R4: younger and own-slot stores ignored
    clear_slots(); put(6, 1, 1, 32'h40); put(7, 1, 0, 32'h0); put(5, 1, 0, 32'h0);
    step("R4 younger stores");
    check(4'b1000, "R4 direct value");

    // R3: unknown older address, non-matching field
    clear_slots(); put(2, 1, 0, 32'h99);
    step("R3 unknown older");
    check(4'b0101, "R3 direct value");

    // R6: wraparound, head=6 load=1, slot 7 older match
    head = 3'd6; ld_idx = 3'd1;
    clear_slots(); put(7, 1, 1, 32'h40); put(3, 1, 1, 32'h40);
    step("R6 wrap older");
    check(4'b0110, "R6 wrap value");
    clear_slots(); put(3, 1, 1, 32'h40); put(2, 1, 0, 32'h0); put(1, 1, 0, 32'h0);
    step("R6 wrap younger");
    check(4'b1000, "R6 wrap younger value");
    head = 3'd4; ld_idx = 3'd4; clear_slots(); put(3, 1, 0, 32'h0); put(0, 1, 1, 32'h40);
    step("R6 load at head");
    check(4'b1000, "R6 head value");

    // R9: stall clears the cycle after the store leaves
    head = 3'd0; ld_idx = 3'd5; clear_slots(); put(0, 1, 1, 32'h40);
    step("R9 stalled");
    st_valid[0] = 1'b0; head = 3'd1;
    step("R9 released");
    check(4'b1000, "R9 go value");

    // R10: both reasons at once
    clear_slots(); put(1, 1, 1, 32'h40); put(2, 1, 0, 32'h7);
    step("R10 both reasons");
    check(4'b0111, "R10 direct value");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] e;
      string tag;
      ld_req  = ($urandom % 8) != 0;
      head    = IW'($urandom);
      ld_idx  = IW'($urandom);
      ld_addr = 32'h100 + ($urandom % 4);
      for (int j = 0; j < DEPTH; j++)
        put(j, ($urandom % 3) == 0, ($urandom % 5) != 0, 32'h100 + ($urandom % 4));
      e = model();
      tag = !ld_req ? "R8 random" : e[0] ? "R3 random" : e[1] ? "R2 random" : "R7 random";
      step(tag);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule